// File: doc/BRIEF.md
# Ethernet Power-Down Receive Gate

This block sits between the receive path of an Ethernet MAC and its receive FIFO. It controls a low-power listening mode. Software writes a control word that sets the power-down bit and the two wake enables. While power-down is active, every frame that starts is discarded whole, and no beat of it reaches the FIFO side. The clocks keep running. The block does no clock gating; it only decides which beats pass.

Two external detectors report with single-cycle pulses: one for a magic packet and one for a wake-up frame. A pulse whose type is enabled has three effects. It sets a sticky status bit. It drives the interrupt. If the block is in power-down, it clears the power-down bit on the next clock. The forward/drop decision is made on the first beat of each frame and held until that frame's last beat. Because of this, a mode change in the middle of a frame never cuts the frame short.

Top module: `eth_pd_rx_gate`

## Requirements
- R1: After reset, pd_active is 0, both enables are 0, sts_rdata is 2'b00 and irq is 0.
- R2: A cycle with ctl_we high loads ctl_wdata: bit 0 sets power-down, bit 1 enables magic detection and bit 2 enables wake-frame detection. The new values show from the next cycle. A write takes priority over a wake event in the same cycle.
- R3: A frame whose first beat (rx_valid high with no frame in progress) arrives while pd_active is 1 is dropped entirely: fwd_valid stays 0 for every beat of it.
- R4: While in power-down, a detection pulse of an enabled type clears pd_active on the next cycle. A pulse of a disabled type has no effect on pd_active, status or irq.
- R5: The forward/drop decision is taken on a frame's first beat and kept until its rx_last beat, whatever pd_active does in between.
- R6: sts_rdata bit 0 records an enabled magic detection and bit 1 an enabled wake-frame detection. Each bit is sticky. A cycle with sts_re high clears both bits from the next cycle on. A detection in the same cycle as the read wins over the clear.
- R7: irq is high when the magic status bit is set with magic detection enabled, or the wake status bit is set with wake detection enabled, using the current enables.
- R8: A forwarded beat presents rx_data and rx_last on fwd_data and fwd_last in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | {wake enable, magic enable, power-down} |
| sts_re | input | 1 | Status read strobe, clears status next cycle |
| sts_rdata | output | 2 | {wake received, magic received} |
| magic_det | input | 1 | Magic-packet detected pulse |
| wake_det | input | 1 | Wake-up frame detected pulse |
| rx_valid | input | 1 | Receive beat valid |
| rx_data | input | DW | Receive beat data |
| rx_last | input | 1 | Last beat of frame |
| fwd_valid | output | 1 | Forwarded beat valid |
| fwd_data | output | DW | Forwarded beat data |
| fwd_last | output | 1 | Forwarded last beat |
| pd_active | output | 1 | Power-down mode active |
| irq | output | 1 | Wake interrupt |

## Verification
The assertions take for granted that rx_last is only raised with rx_valid, so frame boundaries are well formed. They also assume the detector pulses are not held across a control write in a way that hides the next-cycle power-down value. The stimulus table raises rx_last only on valid beats. It places every control write in a cycle without an enabled detection, and it also covers frames that straddle a mode change in both directions.

// File: rtl/eth_pd_rx_gate.sv
module eth_pd_rx_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [2:0]    ctl_wdata,
  input  logic          sts_re,
  output logic [1:0]    sts_rdata,
  input  logic          magic_det,
  input  logic          wake_det,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data,
  output logic          fwd_last,
  output logic          pd_active,
  output logic          irq
);

  logic pd_q, magic_en, wake_en, magic_sts, wake_sts;
  logic in_frame, pass_q, pass_now;
  logic magic_hit, wake_hit;

  assign magic_hit = magic_det & magic_en;
  assign wake_hit  = wake_det & wake_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q     <= 1'b0;
      magic_en <= 1'b0;
      wake_en  <= 1'b0;
    end else if (ctl_we) begin
      pd_q     <= ctl_wdata[0];
      magic_en <= ctl_wdata[1];
      wake_en  <= ctl_wdata[2];
    end else if (magic_hit | wake_hit) begin
      pd_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      magic_sts <= 1'b0;
      wake_sts  <= 1'b0;
    end else begin
      magic_sts <= magic_hit | (magic_sts & ~sts_re);
      wake_sts  <= wake_hit  | (wake_sts  & ~sts_re);
    end
  end

  assign pass_now = in_frame ? pass_q : ~pd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      pass_q   <= 1'b0;
    end else if (rx_valid) begin
      in_frame <= ~rx_last;
      pass_q   <= pass_now;
    end
  end

  assign fwd_valid = rx_valid & pass_now;
  assign fwd_data  = rx_data;
  assign fwd_last  = rx_last & fwd_valid;
  assign pd_active = pd_q;
  assign sts_rdata = {wake_sts, magic_sts};
  assign irq       = (magic_sts & magic_en) | (wake_sts & wake_en);

endmodule

module eth_pd_rx_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [2:0] ctl_wdata,
  input logic       sts_re,
  input logic [1:0] sts_rdata,
  input logic       rx_valid,
  input logic       fwd_valid,
  input logic       pd_active,
  input logic       irq,
  input logic       in_frame,
  input logic       magic_hit,
  input logic       wake_hit
);

  a_r2_write_pd: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> pd_active == $past(ctl_wdata[0]));

  a_r4_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && (magic_hit || wake_hit) && !ctl_we |=> !pd_active);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && !magic_hit && !wake_hit && !ctl_we |=> pd_active);

  a_r3_drop_start: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && rx_valid && !in_frame |-> !fwd_valid);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rdata[0] && !sts_re |=> sts_rdata[0]);

  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts_rdata != 2'b00);

endmodule

bind eth_pd_rx_gate eth_pd_rx_gate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .sts_re(sts_re), .sts_rdata(sts_rdata), .rx_valid(rx_valid),
  .fwd_valid(fwd_valid), .pd_active(pd_active), .irq(irq),
  .in_frame(in_frame), .magic_hit(magic_hit), .wake_hit(wake_hit)
);

// File: tb/eth_pd_rx_gate_tb.sv
module eth_pd_rx_gate_tb_top;
  localparam int DW = 8;
  localparam int NV = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, sts_re = 0, magic_det = 0, wake_det = 0;
  logic rx_valid = 0, rx_last = 0;
  logic [2:0] ctl_wdata = '0;
  logic [DW-1:0] rx_data = '0;
  logic [1:0] sts_rdata;
  logic fwd_valid, fwd_last, pd_active, irq;
  logic [DW-1:0] fwd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eth_pd_rx_gate #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_re(sts_re), .sts_rdata(sts_rdata), .magic_det(magic_det),
    .wake_det(wake_det), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .fwd_last(fwd_last), .pd_active(pd_active), .irq(irq)
  );

  // {we, wdata[2:0], magic, wake, valid, last, exp_fwd, exp_pd, exp_irq}
  localparam logic [10:0] VEC [NV] = '{
    11'b0_000_0_0_1_0_1_0_0, // 0  R8 normal start
    11'b0_000_0_0_1_1_1_0_0, // 1  R8 normal end
    11'b1_011_0_0_0_0_0_0_0, // 2  R2 pd + magic enable
    11'b0_000_0_0_1_0_0_1_0, // 3  R3 start dropped
    11'b0_000_0_1_1_0_0_1_0, // 4  R4 disabled wake ignored
    11'b0_000_1_0_1_0_0_1_0, // 5  R4 enabled magic
    11'b0_000_0_0_1_1_0_0_1, // 6  R5 rest of dropped frame, R7 irq
    11'b0_000_0_0_1_0_1_0_1, // 7  R5 new frame passes
    11'b0_000_0_0_1_1_1_0_1, // 8
    11'b1_101_0_0_0_0_0_0_1, // 9  R2 pd + wake enable only
    11'b0_000_0_0_1_1_0_1_0, // 10 R3 single beat dropped, R7 magic disabled
    11'b0_000_1_0_0_0_0_1_0, // 11 R4 disabled magic ignored
    11'b0_000_0_1_0_0_0_1_0, // 12 R4 enabled wake
    11'b0_000_0_0_1_1_1_0_1, // 13 R4 exit, R6 wake status
    11'b0_000_0_0_1_0_1_0_1, // 14 R5 frame start
    11'b1_101_0_0_1_0_1_0_1, // 15 R5 enter pd mid frame
    11'b0_000_0_0_1_1_1_1_1, // 16 R5 frame completes
    11'b0_000_0_0_1_1_0_1_1  // 17 R3 next frame dropped
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ctl_we = 0; sts_re = 0; magic_det = 0; wake_det = 0; rx_valid = 0; rx_last = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rx_valid = 1; #1;
    check("R1 pd", {7'b0, pd_active}, 8'd0);
    check("R1 irq", {7'b0, irq}, 8'd0);
    check("R1 sts", {6'b0, sts_rdata}, 8'd0);
    rx_valid = 0;
    rst_n = 1;
    @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ctl_we, ctl_wdata, magic_det, wake_det, rx_valid, rx_last} = VEC[i][10:3];
      rx_data = DW'(i + 8'h40);
      #1;
      check($sformatf("R3/R5 fwd_valid row %0d", i), {7'b0, fwd_valid}, {7'b0, VEC[i][2]});
      check($sformatf("R2/R4 pd row %0d", i), {7'b0, pd_active}, {7'b0, VEC[i][1]});
      check($sformatf("R7 irq row %0d", i), {7'b0, irq}, {7'b0, VEC[i][0]});
      if (VEC[i][2]) begin
        check("R8 data", 8'(fwd_data), 8'(i + 8'h40));
        check("R8 last", {7'b0, fwd_last}, {7'b0, VEC[i][3]});
      end
      @(posedge clk);
    end

    // R6 both sticky bits set, read clears next cycle
    @(negedge clk); idle(); sts_re = 1; #1;
    check("R6 sticky both", {6'b0, sts_rdata}, 8'd3);
    @(posedge clk); @(negedge clk); idle(); #1;
    check("R6 cleared", {6'b0, sts_rdata}, 8'd0);
    check("R7 irq after clear", {7'b0, irq}, 8'd0);
    check("R4 pd still set", {7'b0, pd_active}, 8'd1);

    // R6 detection same cycle as read wins; R4 wake exit
    sts_re = 1; wake_det = 1;
    @(posedge clk); @(negedge clk); idle(); #1;
    check("R6 set beats clear", {6'b0, sts_rdata}, 8'd2);
    check("R4 exit", {7'b0, pd_active}, 8'd0);

    // R2 write wins over wake event in same cycle
    ctl_we = 1; ctl_wdata = 3'b101; @(posedge clk);
    @(negedge clk); idle(); ctl_we = 1; ctl_wdata = 3'b101; wake_det = 1;
    @(posedge clk); @(negedge clk); idle(); #1;
    check("R2 write priority", {7'b0, pd_active}, 8'd1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule